// File: doc/BRIEF.md
# Universal registered bus transceiver

This block connects two parallel buses, A and B, through two channels that each carry data in one direction only. The A-to-B channel takes data from the A bus and drives it onto the B bus. The B-to-A channel does the reverse. Each channel has four controls of its own: an output enable, a latch enable, a channel clock and a clock enable.

With these controls a channel works in one of three ways. It can pass its input straight through. It can hold a stored word while its clock stays at one level. Or it can capture a new word on a falling transition of its clock. The outputs are 3-state, modelled as a data vector plus a drive flag, and a disabled output drives zero data. Each input bus has a keeper in front of it. The keeper takes per-bit "driven" flags and substitutes the last driven level on any bit that is left floating. The data is never inverted.

The block runs from a free-running sampling clock `clk`. Each channel clock is an ordinary input that is sampled on that clock. A falling transition counts as seen at the first `clk` edge where the channel clock reads low after it read high at the previous edge. The word captured is the input value present at that edge.

Top module: `ubt_xcvr`

## Requirements
- R1: The parameter `W` (default 18) sets the width of every data port. During `rst_n` low, both stored words and both keepers clear to zero. On the first cycle after reset, an enabled output with its latch enable low therefore shows zero.
- R2: While `ab_le` is 1, `b_out` equals the effective A input in the same cycle, without inversion and without a clock edge. The effective input is `a_in` on driven bits and the keeper value on the other bits.
- R3: While `ab_le` is 0, `b_out` shows the stored A-to-B word. That word changes only on a capture (R4). Its value equals the effective input at the last `clk` edge where `ab_le` was 1, or at the last capture, whichever came later.
- R4: Suppose `ab_le` is 0 and `ab_ce_n` is 0 at a `clk` edge where `ab_cp` reads 0 and read 1 at the previous edge. Then the effective A input at that edge is stored, and it appears on `b_out` from that edge onward.
- R5: Suppose `ab_ce_n` is 1 at a `clk` edge that would otherwise capture. Then the stored word is left unchanged. `ab_ce_n` has no effect while `ab_le` is 1.
- R6: When `ab_oe_n` is 1, `b_drive` is 0 and `b_out` is all zeros. When `ab_oe_n` is 0, `b_drive` is 1.
- R7: The B-to-A channel follows R2 through R6 using `b_in`, `b_in_drv`, `ba_le`, `ba_cp`, `ba_ce_n` and `ba_oe_n`, and drives `a_out` and `a_drive`. Neither channel's controls affect the other channel's outputs.
- R8: A bit whose drive flag (`a_in_drv` / `b_in_drv`) is 0 takes, as its effective input, the level that bit had at the last `clk` edge where its flag was 1. The level is 0 if the flag has not been 1 since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | W | A bus data seen by the A-to-B channel |
| a_in_drv | input | W | Per-bit flag: A bus bit is driven |
| b_in | input | W | B bus data seen by the B-to-A channel |
| b_in_drv | input | W | Per-bit flag: B bus bit is driven |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_cp | input | 1 | A-to-B channel clock, captures on falling transition |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_cp | input | 1 | B-to-A channel clock |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| b_out | output | W | Data driven onto the B bus |
| b_drive | output | 1 | 1 = B bus driven, 0 = high impedance |
| a_out | output | W | Data driven onto the A bus |
| a_drive | output | 1 | 1 = A bus driven, 0 = high impedance |

## Verification
A capture (R4) and the keeper taking over a bit (R8) can fall on the same `clk` edge. This happens when drive flags drop in the very cycle the channel clock is first seen low, and the stored word must then take the kept level, not the abandoned input value. Random stimulus clears random drive-flag masks while the channel clocks toggle. Directed cases also release all flags exactly on a capturing edge. A bench reference model updated at every edge judges the result. A second overlap is the latch enable falling in the same cycle as a clock fall. The same model covers it, because transparent loading and capture both take the effective input.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
    typedef enum logic [0:0] {
        CP_LOW  = 1'b0,
        CP_HIGH = 1'b1
    } cp_state_e;

    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_BLOCKED = 2'd2,
        ST_HOLD    = 2'd3
    } load_kind_e;
endpackage

// File: rtl/ubt_keeper.sv
module ubt_keeper #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] drv,
    output logic [W-1:0] eff
);
    logic [W-1:0] kept_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                kept_q[i] <= 1'b0;
            end else if (drv[i]) begin
                kept_q[i] <= raw[i];
            end
        end

        assign eff[i] = drv[i] ? raw[i] : kept_q[i];
    end
endmodule

// File: rtl/ubt_channel.sv
module ubt_channel
    import ubt_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         cp,
    input  logic         ce_n,
    input  logic         oe_n,
    output logic [W-1:0] dout,
    output logic         drive
);
    cp_state_e    cp_state, cp_next;
    load_kind_e   kind;
    logic [W-1:0] word_q;

    // state register: tracks the channel clock level seen at the last edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_state <= cp ? CP_HIGH : CP_LOW;
        end else begin
            cp_state <= cp_next;
        end
    end

    // next state and load decision
    always_comb begin
        cp_next = cp ? CP_HIGH : CP_LOW;
        kind    = ST_HOLD;
        unique case (cp_state)
            CP_HIGH: begin
                if (le)        kind = ST_PASS;
                else if (!cp)  kind = ce_n ? ST_BLOCKED : ST_CAPTURE;
                else           kind = ST_HOLD;
            end
            CP_LOW: begin
                kind = le ? ST_PASS : ST_HOLD;
            end
            default: kind = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (kind == ST_PASS || kind == ST_CAPTURE) begin
            word_q <= din;
        end
    end

    // outputs
    always_comb begin
        drive = !oe_n;
        dout  = '0;
        if (!oe_n) begin
            dout = le ? din : word_q;
        end
    end
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_in_drv,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_in_drv,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_cp,
    input  logic         ab_ce_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_cp,
    input  logic         ba_ce_n,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    output logic [W-1:0] a_out,
    output logic         a_drive
);
    logic [W-1:0] a_eff, b_eff;

    ubt_keeper #(.W(W)) u_keep_a (
        .clk(clk), .rst_n(rst_n), .raw(a_in), .drv(a_in_drv), .eff(a_eff)
    );

    ubt_keeper #(.W(W)) u_keep_b (
        .clk(clk), .rst_n(rst_n), .raw(b_in), .drv(b_in_drv), .eff(b_eff)
    );

    ubt_channel #(.W(W)) u_ab (
        .clk(clk), .rst_n(rst_n), .din(a_eff), .le(ab_le), .cp(ab_cp),
        .ce_n(ab_ce_n), .oe_n(ab_oe_n), .dout(b_out), .drive(b_drive)
    );

    ubt_channel #(.W(W)) u_ba (
        .clk(clk), .rst_n(rst_n), .din(b_eff), .le(ba_le), .cp(ba_cp),
        .ce_n(ba_ce_n), .oe_n(ba_oe_n), .dout(a_out), .drive(a_drive)
    );
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_in_drv,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_in_drv,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_cp,
    input logic         ab_ce_n,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_cp,
    input logic         ba_ce_n,
    input logic [W-1:0] b_out,
    input logic         b_drive,
    input logic [W-1:0] a_out,
    input logic         a_drive
);
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_oe_n && ab_le && (&a_in_drv)) |-> (b_out == a_in));

    a_r4_capture_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ab_cp) && !ab_le && !ab_ce_n && (&a_in_drv))
        |=> (ab_le || ab_oe_n || b_out == $past(a_in)));

    a_r5_enable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ab_cp) && !ab_le && ab_ce_n && !ab_oe_n)
        |=> (ab_le || ab_oe_n || $stable(b_out)));

    a_r6_release_b: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe_n |-> (!b_drive && b_out == '0));

    a_r7_release_a: assert property (@(posedge clk) disable iff (!rst_n)
        ba_oe_n |-> (!a_drive && a_out == '0));

    a_r7_pass_through_ba: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_oe_n && ba_le && (&b_in_drv)) |-> (a_out == b_in));

    a_r8_keeper_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_oe_n && ab_le && a_in_drv == '0 && $past(rst_n)
         && $past(!ab_oe_n) && $past(ab_le)) |-> $stable(b_out));
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/ubt_xcvr_tb_top.sv
module ubt_xcvr_tb_top;
    localparam int W = 18;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, a_in_drv = '1, b_in = '0, b_in_drv = '1;
    logic         ab_oe_n = 1'b0, ab_le = 1'b0, ab_cp = 1'b0, ab_ce_n = 1'b0;
    logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_cp = 1'b0, ba_ce_n = 1'b0;
    logic [W-1:0] b_out, a_out;
    logic         b_drive, a_drive;

    int n_chk = 0, n_bad = 0, n_cont = 0;

    // reference model state
    logic [W-1:0] m_ab_st = '0, m_ab_keep = '0, m_ba_st = '0, m_ba_keep = '0;
    logic         m_ab_hi = 1'b0, m_ba_hi = 1'b0;
    string        m_ab_last = "R1", m_ba_last = "R1";

    always #2.5 clk = ~clk;

    ubt_xcvr #(.W(W)) dut_i (.*);

    function automatic logic [W-1:0] eff_f(logic [W-1:0] raw, logic [W-1:0] drv,
                                           logic [W-1:0] keep);
        return (raw & drv) | (keep & ~drv);
    endfunction

    function automatic logic [W-1:0] exp_out_f(logic oe_n, logic le, logic [W-1:0] e,
                                               logic [W-1:0] st);
        if (oe_n) return '0;
        return le ? e : st;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp,
                         logic dact, logic dexp);
        n_chk++;
        if (act !== exp || dact !== dexp) begin
            n_bad++;
            $display("FAIL %s: data %h drive %b, expected data %h drive %b",
                     tag, act, dact, exp, dexp);
        end
    endtask

    task automatic check_all();
        logic [W-1:0] ea, eb;
        string ta, tb;
        ea = eff_f(a_in, a_in_drv, m_ab_keep);
        eb = eff_f(b_in, b_in_drv, m_ba_keep);
        if (ab_oe_n)                ta = "R6";
        else if (a_in_drv != ONES)  ta = "R8";
        else if (ab_le)             ta = "R2";
        else if (m_ab_last == "R3") ta = "R3";
        else                        ta = m_ab_last;
        tb = "R7";
        if (b_in_drv != ONES) tb = "R7/R8";
        check(ta, b_out, exp_out_f(ab_oe_n, ab_le, ea, m_ab_st), b_drive, !ab_oe_n);
        check(tb, a_out, exp_out_f(ba_oe_n, ba_le, eb, m_ba_st), a_drive, !ba_oe_n);
        if (!ab_oe_n && !ba_oe_n) n_cont++;
    endtask

    task automatic model_edge();
        logic [W-1:0] ea, eb;
        ea = eff_f(a_in, a_in_drv, m_ab_keep);
        eb = eff_f(b_in, b_in_drv, m_ba_keep);
        if (!rst_n) begin
            m_ab_st = '0; m_ab_keep = '0; m_ba_st = '0; m_ba_keep = '0;
            m_ab_last = "R1"; m_ba_last = "R1";
        end else begin
            m_ab_keep = ea; m_ba_keep = eb;
            if (ab_le) begin
                m_ab_st = ea; m_ab_last = "R3";
            end else if (m_ab_hi && !ab_cp) begin
                if (!ab_ce_n) begin m_ab_st = ea; m_ab_last = "R4"; end
                else m_ab_last = "R5";
            end else if (m_ab_last != "R1") m_ab_last = "R3";
            if (ba_le) m_ba_st = eb;
            else if (m_ba_hi && !ba_cp && !ba_ce_n) m_ba_st = eb;
        end
        m_ab_hi = ab_cp; m_ba_hi = ba_cp;
    endtask

    // one cycle: inputs already set after a negedge; check, then advance model
    task automatic step();
        #1;
        check_all();
        @(posedge clk);
        #0.5;
        model_edge();
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        repeat (3) begin
            @(posedge clk); #0.5; model_edge(); @(negedge clk);
        end
        rst_n = 1'b1;
        ba_oe_n = 1'b0;
        // R1: first cycle after reset, latched mode shows cleared store
        a_in = 18'h2AAAA; b_in = 18'h15555;
        step();

        // R2 then R3: transparent, then drop latch enable, change input
        ab_le = 1'b1; a_in = 18'h3C3C3; step();
        ab_le = 1'b0; a_in = 18'h00FFF; step();
        step();

        // R4: clock high, then low with new data (capture)
        ab_cp = 1'b1; a_in = 18'h12345; step();
        ab_cp = 1'b0; a_in = 18'h2BEEF; step();
        a_in = 18'h00001; step();

        // R5: blocked edge
        ab_ce_n = 1'b1; ab_cp = 1'b1; step();
        ab_cp = 1'b0; a_in = 18'h3FFFF; step();
        ab_le = 1'b1; step();              // ce_n ignored while transparent
        ab_le = 1'b0; ab_ce_n = 1'b0; step();

        // R8 overlapping R4: drive flags drop on the capturing edge
        ab_cp = 1'b1; a_in = 18'h0F0F0; step();
        ab_cp = 1'b0; a_in_drv = '0; a_in = 18'h3FFFF; step();
        a_in_drv = '1; a_in = 18'h11111; step();

        // R6: outputs released
        ab_oe_n = 1'b1; ba_oe_n = 1'b1; step();
        ab_oe_n = 1'b0; ba_oe_n = 1'b0;

        // R7: B-to-A capture while A-to-B transparent
        ba_cp = 1'b1; b_in = 18'h2468A; ab_le = 1'b1; step();
        ba_cp = 1'b0; step();
        b_in = 18'h0; step();
        ab_le = 1'b0;

        // random mix
        for (int i = 0; i < 4000; i++) begin
            a_in    = W'($urandom);
            b_in    = W'($urandom);
            a_in_drv = ($urandom_range(0, 3) == 0) ? W'($urandom) : ONES;
            b_in_drv = ($urandom_range(0, 3) == 0) ? W'($urandom) : ONES;
            ab_le   = ($urandom_range(0, 3) == 0);
            ba_le   = ($urandom_range(0, 3) == 0);
            ab_cp   = $urandom_range(0, 1) == 1;
            ba_cp   = $urandom_range(0, 1) == 1;
            ab_ce_n = ($urandom_range(0, 2) == 0);
            ba_ce_n = ($urandom_range(0, 2) == 0);
            ab_oe_n = ($urandom_range(0, 4) == 0);
            ba_oe_n = ($urandom_range(0, 4) == 0);
            step();
        end

        $display("note: %0d cycles with both directions driving (bus contention)", n_cont);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule